// File: doc/BRIEF.md
# Paged Address Translator with Split Instruction and Data Maps

This block sits between a 16-bit processor and a 1 MB physical memory. It turns each 16-bit logical address into a 20-bit physical address. Memory is divided into 2 KB pages. The top five logical address bits pick a page register, and that register supplies the upper nine physical address bits. The low eleven bits pass through unchanged. Each page register also holds a valid bit and a write-permission bit. An access that breaks either one is refused.

The block holds sixteen independent map sets, one for each process context. Each map set has two maps: one used for instruction fetches and one used for data accesses. This lets a program's code and data sit in separate spaces. A 4-bit map-set register picks the set in use. Supervisor code loads the page registers and the map-set register through a simple write port.

Translation is combinational within the access cycle. The fault indication, its cause and the faulting logical address are captured in registers at the clock edge that ends the access.

Top module: `split_page_mmu`

## Requirements
- R1: After a synchronous reset, every page register is invalid, the active map set is 0 and the fault flag is low. Any access made before configuration therefore faults with cause "invalid".
- R2: A configuration write with `cfg_kind`=1 loads `cfg_data[3:0]` into the map-set register. `cur_set` shows the new value from the next cycle on. Accesses in later cycles translate through that set only.
- R3: Accesses with `acc_fetch`=1 use the instruction map, which is configured with `cfg_ispace`=1. Accesses with `acc_fetch`=0 use the data map (`cfg_ispace`=0). The two maps of a set are independent.
- R4: The page register is selected by `acc_addr[15:11]`. This gives 32 registers per map, and pages 0 and 31 are distinct.
- R5: On an allowed access, `phys_addr[10:0]` equals `acc_addr[10:0]`, `phys_addr[19:11]` equals the page frame, and `phys_ok` is 1.
- R6: An access to an invalid page drives `phys_ok` to 0 and `phys_addr` to 0. It also records fault cause 2'b01.
- R7: A write (`acc_write`=1) to a valid page whose write-permission bit is 0 is refused with fault cause 2'b10. Reads of that same page are allowed.
- R8: At the edge that ends a refused access, the block sets `fault_flag` to 1, loads `fault_cause` and loads `fault_addr` with the logical address. After a cycle with an allowed access or no access, `fault_flag` is 0 and `fault_cause` is 2'b00. `fault_addr` keeps the address of the last refused access.
- R9: A page-register write with `cfg_kind`=0 stores fields from `cfg_data`: bit 10 is valid, bit 9 is writable and bits 8:0 are the frame. The entry stored is the one selected by `cfg_set`, `cfg_ispace` and `cfg_page`.
- R10: A page-register write is used by an access in the very next cycle. An access in the same cycle as the write still sees the old contents.
- R11: When a page is both invalid and not writable, a write to it reports cause "invalid" (2'b01) rather than write-protect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_kind | input | 1 | 0: page register write, 1: map-set register write |
| cfg_set | input | 4 | Map set of the page register written |
| cfg_ispace | input | 1 | 1: instruction map, 0: data map |
| cfg_page | input | 5 | Page index of the register written |
| cfg_data | input | 11 | {valid, writable, frame[8:0]}, or the new map set in [3:0] |
| acc_valid | input | 1 | Access strobe |
| acc_fetch | input | 1 | 1: instruction fetch, 0: data access |
| acc_write | input | 1 | 1: write access |
| acc_addr | input | 16 | Logical address |
| phys_addr | output | 20 | Translated physical address (0 when refused) |
| phys_ok | output | 1 | Access allowed and translated |
| fault_flag | output | 1 | Registered: previous cycle's access was refused |
| fault_cause | output | 2 | Registered cause: 00 none, 01 invalid, 10 write-protect |
| fault_addr | output | 16 | Logical address of the last refused access |
| cur_set | output | 4 | Active map set |

## Verification
Instruction and data accesses go to the same page index with different frames loaded in each map. A swap of the two maps shows up as the wrong frame. Pages 0 and 31 and all-ones offsets are used to show up index or offset slicing errors. Reads and writes go to read-only pages, and writes go to pages that are both invalid and read-only, to separate the two fault causes and their priority. Writes back to back with accesses, and map-set switches, show the one-cycle visibility rule. A long run of random configuration writes and accesses is compared on every clock against a behavioural model.

// File: rtl/mmu_pkg.sv
package mmu_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE    = 2'b00,
    CAUSE_INVALID = 2'b01,
    CAUSE_WPROT   = 2'b10
  } cause_e;
endpackage

// File: rtl/mmu_map_store.sv
// Page register file: frame and write bit in an array with no reset,
// valid bits in flops so reset can clear them all at once.
module mmu_map_store #(
  parameter int SET_W   = 4,
  parameter int PAGE_W  = 5,
  parameter int FRAME_W = 9
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                wr_en,
  input  logic [SET_W+PAGE_W:0]               wr_idx,
  input  logic                                wr_valid,
  input  logic                                wr_writable,
  input  logic [FRAME_W-1:0]                  wr_frame,
  input  logic [SET_W+PAGE_W:0]               rd_idx,
  output logic                                rd_valid,
  output logic                                rd_writable,
  output logic [FRAME_W-1:0]                  rd_frame
);
  localparam int IDX_W = SET_W + 1 + PAGE_W;
  localparam int DEPTH = 1 << IDX_W;

  logic [FRAME_W:0]   mem [DEPTH];
  logic [DEPTH-1:0]   vld_q;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= {wr_writable, wr_frame};
  end

  always_ff @(posedge clk) begin
    if (rst)        vld_q <= '0;
    else if (wr_en) vld_q[wr_idx] <= wr_valid;
  end

  always_comb begin
    rd_valid    = vld_q[rd_idx];
    rd_writable = mem[rd_idx][FRAME_W];
    rd_frame    = mem[rd_idx][FRAME_W-1:0];
  end
endmodule

// File: rtl/mmu_set_reg.sv
module mmu_set_reg #(
  parameter int SET_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [SET_W-1:0] din,
  output logic [SET_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (we) q <= din;
  end
endmodule

// File: rtl/mmu_xlate.sv
module mmu_xlate
  import mmu_pkg::*;
#(
  parameter int OFF_W   = 11,
  parameter int FRAME_W = 9
) (
  input  logic                       acc_valid,
  input  logic                       acc_write,
  input  logic [OFF_W-1:0]           offset,
  input  logic                       ent_valid,
  input  logic                       ent_writable,
  input  logic [FRAME_W-1:0]         ent_frame,
  output logic [FRAME_W+OFF_W-1:0]   pa,
  output logic                       ok,
  output cause_e                     cause
);
  always_comb begin
    cause = CAUSE_NONE;
    if (acc_valid) begin
      if (!ent_valid)                    cause = CAUSE_INVALID;
      else if (acc_write && !ent_writable) cause = CAUSE_WPROT;
    end
    ok = acc_valid && (cause == CAUSE_NONE);
    pa = ok ? {ent_frame, offset} : '0;
  end
endmodule

// File: rtl/mmu_fault_capture.sv
module mmu_fault_capture
  import mmu_pkg::*;
#(
  parameter int LA_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  cause_e          cause,
  input  logic [LA_W-1:0] addr,
  output logic            flag,
  output logic [1:0]      cause_q,
  output logic [LA_W-1:0] addr_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      flag    <= 1'b0;
      cause_q <= CAUSE_NONE;
      addr_q  <= '0;
    end else begin
      flag    <= (cause != CAUSE_NONE);
      cause_q <= cause;
      if (cause != CAUSE_NONE) addr_q <= addr;
    end
  end
endmodule

// File: rtl/split_page_mmu.sv
module split_page_mmu
  import mmu_pkg::*;
#(
  parameter int LA_W  = 16,
  parameter int PA_W  = 20,
  parameter int OFF_W = 11,
  parameter int SET_W = 4,
  localparam int PAGE_W  = LA_W - OFF_W,
  localparam int FRAME_W = PA_W - OFF_W,
  localparam int CFG_W   = FRAME_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic              cfg_kind,
  input  logic [SET_W-1:0]  cfg_set,
  input  logic              cfg_ispace,
  input  logic [PAGE_W-1:0] cfg_page,
  input  logic [CFG_W-1:0]  cfg_data,
  input  logic              acc_valid,
  input  logic              acc_fetch,
  input  logic              acc_write,
  input  logic [LA_W-1:0]   acc_addr,
  output logic [PA_W-1:0]   phys_addr,
  output logic              phys_ok,
  output logic              fault_flag,
  output logic [1:0]        fault_cause,
  output logic [LA_W-1:0]   fault_addr,
  output logic [SET_W-1:0]  cur_set
);
  localparam int IDX_W = SET_W + 1 + PAGE_W;

  logic [IDX_W-1:0]   wr_idx, rd_idx;
  logic               ent_valid, ent_writable;
  logic [FRAME_W-1:0] ent_frame;
  cause_e             cause;

  assign wr_idx = {cfg_set, cfg_ispace, cfg_page};
  assign rd_idx = {cur_set, acc_fetch, acc_addr[LA_W-1:OFF_W]};

  mmu_set_reg #(.SET_W(SET_W)) u_set (
    .clk(clk), .rst(rst), .we(cfg_we && cfg_kind),
    .din(cfg_data[SET_W-1:0]), .q(cur_set)
  );

  mmu_map_store #(.SET_W(SET_W), .PAGE_W(PAGE_W), .FRAME_W(FRAME_W)) u_store (
    .clk(clk), .rst(rst),
    .wr_en(cfg_we && !cfg_kind), .wr_idx(wr_idx),
    .wr_valid(cfg_data[FRAME_W+1]), .wr_writable(cfg_data[FRAME_W]),
    .wr_frame(cfg_data[FRAME_W-1:0]),
    .rd_idx(rd_idx), .rd_valid(ent_valid), .rd_writable(ent_writable),
    .rd_frame(ent_frame)
  );

  mmu_xlate #(.OFF_W(OFF_W), .FRAME_W(FRAME_W)) u_xlate (
    .acc_valid(acc_valid), .acc_write(acc_write),
    .offset(acc_addr[OFF_W-1:0]),
    .ent_valid(ent_valid), .ent_writable(ent_writable), .ent_frame(ent_frame),
    .pa(phys_addr), .ok(phys_ok), .cause(cause)
  );

  mmu_fault_capture #(.LA_W(LA_W)) u_fault (
    .clk(clk), .rst(rst), .cause(cause), .addr(acc_addr),
    .flag(fault_flag), .cause_q(fault_cause), .addr_q(fault_addr)
  );
endmodule

// File: rtl/mmu_checker.sv
module mmu_checker #(
  parameter int LA_W  = 16,
  parameter int PA_W  = 20,
  parameter int OFF_W = 11,
  parameter int SET_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_we,
  input logic              cfg_kind,
  input logic [SET_W-1:0]  cfg_data_set,
  input logic              acc_valid,
  input logic              acc_write,
  input logic [LA_W-1:0]   acc_addr,
  input logic [PA_W-1:0]   phys_addr,
  input logic              phys_ok,
  input logic              fault_flag,
  input logic [1:0]        fault_cause,
  input logic [LA_W-1:0]   fault_addr,
  input logic [SET_W-1:0]  cur_set
);
  assert_ok_needs_access_R5: assert property (@(posedge clk) disable iff (rst)
    phys_ok |-> acc_valid && phys_addr[OFF_W-1:0] == acc_addr[OFF_W-1:0]);
  assert_refused_zero_R6: assert property (@(posedge clk) disable iff (rst)
    !phys_ok |-> phys_addr == '0);
  assert_fault_follows_R8: assert property (@(posedge clk) disable iff (rst)
    acc_valid && !phys_ok |=> fault_flag && fault_addr == $past(acc_addr));
  assert_clear_after_ok_R8: assert property (@(posedge clk) disable iff (rst)
    !acc_valid || phys_ok |=> !fault_flag && fault_cause == 2'b00);
  assert_cause_coded_R8: assert property (@(posedge clk) disable iff (rst)
    fault_flag |-> fault_cause == 2'b01 || fault_cause == 2'b10);
  assert_set_load_R2: assert property (@(posedge clk) disable iff (rst)
    cfg_we && cfg_kind |=> cur_set == $past(cfg_data_set));
  assert_set_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !(cfg_we && cfg_kind) |=> $stable(cur_set));
  assert_read_never_wprot_R7: assert property (@(posedge clk) disable iff (rst)
    acc_valid && !acc_write |=> fault_cause != 2'b10);
endmodule

bind split_page_mmu mmu_checker #(.LA_W(LA_W), .PA_W(PA_W), .OFF_W(OFF_W), .SET_W(SET_W)) u_chk (
  .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_kind(cfg_kind),
  .cfg_data_set(cfg_data[SET_W-1:0]), .acc_valid(acc_valid), .acc_write(acc_write),
  .acc_addr(acc_addr), .phys_addr(phys_addr), .phys_ok(phys_ok),
  .fault_flag(fault_flag), .fault_cause(fault_cause), .fault_addr(fault_addr),
  .cur_set(cur_set)
);

// File: tb/split_page_mmu_test.sv
module split_page_mmu_test;
  logic        clk = 0;
  logic        rst;
  logic        cfg_we, cfg_kind, cfg_ispace;
  logic [3:0]  cfg_set;
  logic [4:0]  cfg_page;
  logic [10:0] cfg_data;
  logic        acc_valid, acc_fetch, acc_write;
  logic [15:0] acc_addr;
  logic [19:0] phys_addr;
  logic        phys_ok, fault_flag;
  logic [1:0]  fault_cause;
  logic [15:0] fault_addr;
  logic [3:0]  cur_set;

  always #10 clk = ~clk;

  split_page_mmu uut (.*);

  // behavioural reference model
  bit m_valid [1024];
  bit m_wr    [1024];
  int m_frame [1024];
  int m_set, m_fault, m_cause, m_faddr;
  int n_checks = 0, n_fail = 0, cycles = 0;

  task automatic chk(string req, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // one clock: compare at the falling edge, update model at the rising edge
  task automatic tick(string req);
    int idx, cause, ok, pa;
    #8;
    idx = (m_set << 6) | (int'(acc_fetch) << 5) | int'(acc_addr[15:11]);
    cause = 0;
    if (acc_valid) begin
      if (!m_valid[idx]) cause = 1;
      else if (acc_write && !m_wr[idx]) cause = 2;
    end
    ok = (acc_valid && cause == 0) ? 1 : 0;
    pa = ok ? ((m_frame[idx] << 11) | int'(acc_addr[10:0])) : 0;
    chk(req, "phys_ok", int'(phys_ok), ok);
    chk(req, "phys_addr", int'(phys_addr), pa);
    chk(req, "fault_flag", int'(fault_flag), m_fault);
    chk(req, "fault_cause", int'(fault_cause), m_cause);
    chk(req, "fault_addr", int'(fault_addr), m_faddr);
    chk(req, "cur_set", int'(cur_set), m_set);
    @(posedge clk);
    if (rst) begin
      for (int i = 0; i < 1024; i++) m_valid[i] = 0;
      m_set = 0; m_fault = 0; m_cause = 0; m_faddr = 0;
    end else begin
      m_fault = (cause != 0) ? 1 : 0;
      m_cause = cause;
      if (cause != 0) m_faddr = int'(acc_addr);
      if (cfg_we && cfg_kind) m_set = int'(cfg_data[3:0]);
      if (cfg_we && !cfg_kind) begin
        idx = (int'(cfg_set) << 6) | (int'(cfg_ispace) << 5) | int'(cfg_page);
        m_valid[idx] = cfg_data[10];
        m_wr[idx]    = cfg_data[9];
        m_frame[idx] = int'(cfg_data[8:0]);
      end
    end
    #2;
  endtask

  task automatic idle();
    cfg_we = 0; cfg_kind = 0; cfg_set = 0; cfg_ispace = 0; cfg_page = 0; cfg_data = 0;
    acc_valid = 0; acc_fetch = 0; acc_write = 0; acc_addr = 0;
  endtask

  task automatic wpage(int s, int isp, int pg, int v, int w, int fr, string req);
    idle();
    cfg_we = 1; cfg_kind = 0; cfg_set = 4'(s); cfg_ispace = 1'(isp); cfg_page = 5'(pg);
    cfg_data = {1'(v), 1'(w), 9'(fr)};
    tick(req);
  endtask

  task automatic wset(int s, string req);
    idle();
    cfg_we = 1; cfg_kind = 1; cfg_data = 11'(s);
    tick(req);
  endtask

  task automatic acc(int f, int w, int a, string req);
    idle();
    acc_valid = 1; acc_fetch = 1'(f); acc_write = 1'(w); acc_addr = 16'(a);
    tick(req);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected below 100000", cycles);
      finish_run();
    end
  end

  initial begin
    m_set = 0; m_fault = 0; m_cause = 0; m_faddr = 0;
    idle();
    rst = 1;
    @(posedge clk); #2;
    tick("R1"); tick("R1");
    rst = 0;
    tick("R1");                       // reset state
    acc(0, 0, 16'h1234, "R1");        // unconfigured -> invalid
    idle(); tick("R6");               // fault captured, cause 01
    idle(); tick("R8");               // cleared after idle, addr held
    // R3: same page, different maps
    wpage(0, 0, 3, 1, 1, 9'h155, "R9");
    wpage(0, 1, 3, 1, 0, 9'h0AA, "R9");
    acc(0, 0, 16'h1FFF, "R3");
    acc(1, 0, 16'h1801, "R3");
    // R4: boundary pages
    wpage(0, 0, 0, 1, 1, 9'h001, "R4");
    wpage(0, 0, 31, 1, 1, 9'h1FF, "R4");
    acc(0, 1, 16'hFFFF, "R4");
    acc(0, 0, 16'h0000, "R5");
    acc(0, 0, 16'h07FF, "R5");
    // R7: read-only data page
    wpage(0, 0, 5, 1, 0, 9'h0C3, "R9");
    acc(0, 0, 16'h2ABC, "R7");
    acc(0, 1, 16'h2ABC, "R7");
    acc(0, 0, 16'h2000, "R8");
    // R11: invalid and read-only
    wpage(0, 0, 6, 0, 0, 9'h077, "R11");
    acc(0, 1, 16'h3010, "R11");
    idle(); tick("R11");
    // R10: same cycle vs next cycle
    idle();
    cfg_we = 1; cfg_set = 0; cfg_ispace = 0; cfg_page = 7; cfg_data = {1'b1, 1'b1, 9'h111};
    acc_valid = 1; acc_addr = 16'h3A00;
    tick("R10");                       // old (invalid) contents
    acc(0, 0, 16'h3A00, "R10");        // new contents
    // R2: map set switch
    wpage(9, 0, 3, 1, 1, 9'h0F0, "R2");
    wset(9, "R2");
    acc(0, 0, 16'h1800, "R2");
    acc(1, 0, 16'h1800, "R2");         // set 9 instruction map unconfigured
    idle();
    cfg_we = 1; cfg_kind = 1; cfg_data = 11'd0;
    acc_valid = 1; acc_addr = 16'h1800;
    tick("R2");                        // still set 9 this cycle
    acc(0, 0, 16'h1800, "R2");         // set 0 now
    // random mix
    for (int i = 0; i < 3000; i++) begin
      idle();
      if ($urandom_range(0, 3) == 0) begin
        cfg_we = 1; cfg_kind = ($urandom_range(0, 7) == 0);
        cfg_set = 4'($urandom_range(0, 3)); cfg_ispace = 1'($urandom_range(0, 1));
        cfg_page = 5'($urandom_range(0, 31)); cfg_data = 11'($urandom);
        if (cfg_kind) cfg_data = 11'($urandom_range(0, 3));
      end
      if ($urandom_range(0, 4) != 0) begin
        acc_valid = 1; acc_fetch = 1'($urandom_range(0, 1));
        acc_write = 1'($urandom_range(0, 1)); acc_addr = 16'($urandom);
      end
      tick("R9");
    end
    idle(); tick("R8");
    finish_run();
  end
endmodule